// File: doc/BRIEF.md
# Debug Snapshot Capture Shifter

This block freezes a coherent 64-bit picture of the core's visible state and streams it to the debug port one bit at a time during the port's read phase. The port controller supplies a level that marks the read phase and a one-cycle strobe for every serial bit clock, both synchronous to the block clock. When the read phase begins, every field is latched in the same clock cycle. From then on each strobe moves the stream forward by one bit, so later changes in the core do not tear the picture.

The composite always has the same layout, and the host always clocks out all 64 bits. The coarse, most frequently needed fields come out first: a status byte holding the three condition flags and the core state machine code, then a spare byte whose meaning is chosen by the integrator (for example a selector address or a loopback value), then the 16-bit instruction being decoded, then the program counter, the result value, the source operand and the destination operand. Inside each field the most significant bit leaves first. After the last bit the serial output stays at 0 until the next read phase starts.

Top module: `dbg_snap_shifter`

## Requirements
- R1: While reset is asserted, and after it is released until the first capture, `serOut` is 0.
- R2: On the clock edge where `readPhase` is seen high after having been low, all inputs are latched together. Input changes after that edge do not alter the bits streamed from that capture.
- R3: Stream bit k (k = 0 is the first bit, visible on the cycle after the capture edge) equals bit 63-k of the word {status[7:0], spareByte, curInstr[15:0], pcVal, resultVal, srcVal, dstVal}.
- R4: The status byte is laid out as bit 0 = `flagC`, bit 1 = `flagS`, bit 2 = `flagZ`, bits 7:3 = `fsmState[4:0]`.
- R5: Each `bitStrobe` seen high at a clock edge while `readPhase` is high advances `serOut` to the next stream bit at that edge.
- R6: After 64 strobes `serOut` is 0, and further strobes leave it at 0 until the next capture.
- R7: Strobes seen while `readPhase` is low are ignored: `serOut` keeps its current bit, and the stream resumes from that bit.
- R8: Holding `readPhase` high never causes a second capture. A new low-to-high transition recaptures and restarts the stream at bit 0, even in the middle of a stream.
- R9: A strobe that arrives on the capture edge itself is ignored, and the first stream bit is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| readPhase | input | 1 | High during the port's read phase |
| bitStrobe | input | 1 | One-cycle pulse per serial bit clock |
| flagC | input | 1 | Carry flag |
| flagS | input | 1 | Sign flag |
| flagZ | input | 1 | Zero flag |
| fsmState | input | 5 | Core state machine code |
| spareByte | input | 8 | Integrator-defined spare field |
| curInstr | input | 16 | Instruction currently decoded |
| pcVal | input | 8 | Program counter |
| resultVal | input | 8 | Result value |
| srcVal | input | 8 | Source operand value |
| dstVal | input | 8 | Destination operand value |
| serOut | output | 1 | Serial snapshot bit |

## Verification
The capture is due one clock after the edge where `readPhase` is first seen high: at that point the first stream bit is on `serOut`. Each strobe moves the output at the edge that samples it, so the next bit is valid one cycle later. The bench changes inputs on the falling edge and reads `serOut` at the following falling edge, half a period after the edge that updated it. It pulses each strobe for exactly one cycle and reads the bit before raising the next strobe.

// File: rtl/dbg_snap_pkg.sv
package dbg_snap_pkg;

  // Strobes from the control section to the snapshot datapath.
  typedef struct packed {
    logic capture;   // latch all fields this cycle
    logic shift;     // advance the stream by one bit
    logic outEn;     // stream bits remain to be presented
  } snapCtrl_t;

endpackage

// File: rtl/dbg_snap_ctrl.sv
module dbg_snap_ctrl
  import dbg_snap_pkg::*;
#(
  parameter int SNAP_W = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      readPhase,
  input  logic      bitStrobe,
  output snapCtrl_t ctrl
);

  localparam int CNT_W = $clog2(SNAP_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SNAP_W);

  logic             phaseQ;
  logic [CNT_W-1:0] bitsLeft;
  logic             captureNow;
  logic             shiftNow;

  // Rising edge of the read phase is the capture point; it wins over a strobe.
  assign captureNow = readPhase & ~phaseQ;
  assign shiftNow   = readPhase & bitStrobe & ~captureNow & (bitsLeft != '0);

  always_comb begin
    ctrl.capture = captureNow;
    ctrl.shift   = shiftNow;
    ctrl.outEn   = (bitsLeft != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= 1'b0;
      bitsLeft <= '0;
    end else begin
      phaseQ <= readPhase;
      if (captureNow) begin
        bitsLeft <= FULL_CNT;
      end else if (shiftNow) begin
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  // R2
  capture_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (bitsLeft == FULL_CNT));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readPhase |=> (bitsLeft == $past(bitsLeft)));

  // R5
  shift_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shift |=> (bitsLeft == $past(bitsLeft) - 1'b1));

  // R6
  drained_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((bitsLeft == '0) && !ctrl.capture) |=> (bitsLeft == '0));

endmodule

// File: rtl/dbg_snap_data.sv
module dbg_snap_data
  import dbg_snap_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FSM_W   = 5,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  snapCtrl_t          ctrl,
  input  logic               flagC,
  input  logic               flagS,
  input  logic               flagZ,
  input  logic [FSM_W-1:0]   fsmState,
  input  logic [BYTE_W-1:0]  spareByte,
  input  logic [INSTR_W-1:0] curInstr,
  input  logic [BYTE_W-1:0]  pcVal,
  input  logic [BYTE_W-1:0]  resultVal,
  input  logic [BYTE_W-1:0]  srcVal,
  input  logic [BYTE_W-1:0]  dstVal,
  output logic               serOut
);

  localparam int FLAG_N   = 3;
  localparam int STATUS_W = FLAG_N + FSM_W;
  localparam int SNAP_W   = STATUS_W + BYTE_W + INSTR_W + 4 * BYTE_W;

  logic [STATUS_W-1:0] statusField;
  logic [SNAP_W-1:0]   snapWord;
  logic [SNAP_W-1:0]   shReg;

  // Coarse fields sit at the top so that they leave first.
  assign statusField = {fsmState, flagZ, flagS, flagC};
  assign snapWord    = {statusField, spareByte, curInstr, pcVal, resultVal, srcVal, dstVal};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (ctrl.capture) begin
      shReg <= snapWord;
    end else if (ctrl.shift) begin
      shReg <= {shReg[SNAP_W-2:0], 1'b0};
    end
  end

  assign serOut = ctrl.outEn & shReg[SNAP_W-1];

  // R2
  snap_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (shReg == $past(snapWord)));

  // R5
  shift_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shift |=> (shReg[SNAP_W-1:1] == $past(shReg[SNAP_W-2:0])));

endmodule

// File: rtl/dbg_snap_shifter.sv
module dbg_snap_shifter
  import dbg_snap_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FSM_W   = 5,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               readPhase,
  input  logic               bitStrobe,
  input  logic               flagC,
  input  logic               flagS,
  input  logic               flagZ,
  input  logic [FSM_W-1:0]   fsmState,
  input  logic [BYTE_W-1:0]  spareByte,
  input  logic [INSTR_W-1:0] curInstr,
  input  logic [BYTE_W-1:0]  pcVal,
  input  logic [BYTE_W-1:0]  resultVal,
  input  logic [BYTE_W-1:0]  srcVal,
  input  logic [BYTE_W-1:0]  dstVal,
  output logic               serOut
);

  localparam int SNAP_W = 3 + FSM_W + BYTE_W + INSTR_W + 4 * BYTE_W;

  snapCtrl_t ctrl;

  dbg_snap_ctrl #(.SNAP_W(SNAP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .readPhase (readPhase),
    .bitStrobe (bitStrobe),
    .ctrl      (ctrl)
  );

  dbg_snap_data #(.BYTE_W(BYTE_W), .FSM_W(FSM_W), .INSTR_W(INSTR_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .flagC     (flagC),
    .flagS     (flagS),
    .flagZ     (flagZ),
    .fsmState  (fsmState),
    .spareByte (spareByte),
    .curInstr  (curInstr),
    .pcVal     (pcVal),
    .resultVal (resultVal),
    .srcVal    (srcVal),
    .dstVal    (dstVal),
    .serOut    (serOut)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !serOut);

endmodule

// File: tb/dbg_snap_shifter_bench.sv
`timescale 1ns/1ps
module dbg_snap_shifter_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        readPhase;
  logic        bitStrobe;
  logic        flagC, flagS, flagZ;
  logic [4:0]  fsmState;
  logic [7:0]  spareByte;
  logic [15:0] curInstr;
  logic [7:0]  pcVal, resultVal, srcVal, dstVal;
  logic        serOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dbg_snap_shifter u_dbg_snap_shifter (
    .clk(clk), .rstN(rstN), .readPhase(readPhase), .bitStrobe(bitStrobe),
    .flagC(flagC), .flagS(flagS), .flagZ(flagZ), .fsmState(fsmState),
    .spareByte(spareByte), .curInstr(curInstr), .pcVal(pcVal),
    .resultVal(resultVal), .srcVal(srcVal), .dstVal(dstVal), .serOut(serOut)
  );

  // Stimulus bundle: [63:56] dst, [55:48] src, [47:40] result, [39:32] pc,
  // [31:16] instr, [15:8] spare, [7] C, [6] S, [5] Z, [4:0] fsm.
  localparam logic [63:0] VEC [0:4] = '{
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h1122_3344_5566_77A3,
    64'hA55A_C33C_0FF0_9E4C,
    64'h0180_7E01_8001_FF35
  };

  function automatic logic [63:0] expSnap(logic [63:0] v);
    logic [7:0] st;
    st = {v[4:0], v[5], v[6], v[7]};   // R4 layout: fsm, Z, S, C
    return {st, v[15:8], v[31:16], v[39:32], v[47:40], v[55:48], v[63:56]};
  endfunction

  task automatic applyVec(logic [63:0] v);
    dstVal = v[63:56]; srcVal = v[55:48]; resultVal = v[47:40]; pcVal = v[39:32];
    curInstr = v[31:16]; spareByte = v[15:8];
    flagC = v[7]; flagS = v[6]; flagZ = v[5]; fsmState = v[4:0];
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic capture();
    readPhase = 1'b0;
    @(negedge clk);
    readPhase = 1'b1;
    @(negedge clk);
  endtask

  task automatic readBits(int n, output logic [63:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      w = {w[62:0], serOut};
      bitStrobe = 1'b1;
      @(negedge clk);
      bitStrobe = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] w, ea, eb;
    rstN = 1'b0; readPhase = 1'b0; bitStrobe = 1'b0;
    applyVec(64'h0);
    repeat (3) @(negedge clk);
    check("R1 in reset", {63'd0, serOut}, 64'd0);
    rstN = 1'b1;
    applyVec(VEC[3]);
    readPhase = 1'b1; bitStrobe = 1'b1;   // phase was low through reset: this is a capture
    @(negedge clk);
    readPhase = 1'b0; bitStrobe = 1'b0;
    @(negedge clk);
    readPhase = 1'b0;
    // fresh start from reset with no capture
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    check("R1 after reset", {63'd0, serOut}, 64'd0);

    // Table walk: R3 order, R5 stepping, R6 drain
    for (int k = 0; k < 5; k++) begin
      applyVec(VEC[k]);
      capture();
      ea = expSnap(VEC[k]);
      check("R3 first bit", {63'd0, serOut}, {63'd0, ea[63]});
      readBits(64, w);
      check("R3/R5 full stream", w, ea);
      check("R6 drained", {63'd0, serOut}, 64'd0);
      readBits(3, w);
      check("R6 extra strobes", {63'd0, serOut}, 64'd0);
      readPhase = 1'b0;
      @(negedge clk);
    end

    // R4: single status bits
    applyVec(64'h0000_0000_0000_0040);   // S only
    capture(); readBits(64, w);
    check("R4 S at status bit1", w, 64'h0200_0000_0000_0000);
    applyVec(64'h0000_0000_0000_0010);   // fsm MSB only
    capture(); readBits(64, w);
    check("R4 fsm at status bit7", w, 64'h8000_0000_0000_0000);
    applyVec(64'h0000_0000_0000_0080);   // C only
    capture(); readBits(64, w);
    check("R4 C at status bit0", w, 64'h0100_0000_0000_0000);

    // R2: inputs change after capture do not leak in
    ea = expSnap(VEC[2]); eb = expSnap(VEC[3]);
    applyVec(VEC[2]);
    capture();
    applyVec(VEC[3]);
    readBits(64, w);
    check("R2 coherent capture", w, ea);

    // R7: strobes in low phase ignored, stream resumes
    applyVec(VEC[2]);
    capture();
    readBits(10, w);
    check("R7 partial prefix", w, {54'd0, ea[63:54]});
    readPhase = 1'b0;
    for (int i = 0; i < 5; i++) begin
      bitStrobe = 1'b1; @(negedge clk);
    end
    bitStrobe = 1'b0;
    check("R7 held bit", {63'd0, serOut}, {63'd0, ea[53]});

    // R8: new rising edge mid-stream recaptures and restarts
    applyVec(VEC[3]);
    readPhase = 1'b1;
    @(negedge clk);
    check("R8 restart first bit", {63'd0, serOut}, {63'd0, eb[63]});
    readBits(64, w);
    check("R8 restarted stream", w, eb);

    // R9: strobe coincident with capture edge is ignored
    applyVec(VEC[4]);
    ea = expSnap(VEC[4]);
    readPhase = 1'b0;
    @(negedge clk);
    readPhase = 1'b1; bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
    check("R9 first bit kept", {63'd0, serOut}, {63'd0, ea[63]});
    readBits(64, w);
    check("R9 full stream", w, ea);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule